// File: doc/BRIEF.md
# Slot-Based Serial Audio Port (Master)

This block is a master-mode synchronous serial port for monaural audio. It divides the system clock down to a bit clock and emits a one-bit-wide frame sync pulse at the start of every frame. It places an 8-bit transmit word into one numbered time slot of the frame and collects an 8-bit receive word from another slot. Frames are built from 8-bit slots, and the number of slots comes from a coded length field. The first data bit of a frame follows the sync pulse by one bit period, so the last data bit of a frame shares its bit period with the sync pulse of the next frame.

Transmit words enter through a valid/ready handshake. The port asks for a word in the system cycle just before the first bit of its transmit slot. If no word is offered then, the slot goes out as zeros and an underrun strobe is raised. Each received word is delivered with a one-cycle valid strobe once its last bit has been sampled. A select input chooses the sampling edge: receive data is sampled on one edge of the bit clock, and transmit data and sync change on the other.

Top module: `slot_audio_port`

## Requirements
- R1: `sckOut` is low in reset and toggles every `clkDiv`+1 system clock cycles.
- R2: The frame length is 8×(`frameLenCode[3:2]`+1) bit periods; `frameLenCode[1:0]` has no effect. Code 4'b0000 gives 8 bits and 4'b0100 gives 16 bits.
- R3: `syncOut` is high for exactly one bit period per frame, in the bit period just before data bit 0. The first bit period after reset is a sync period.
- R4: Data bit k of a frame (k counted from 0, starting one bit period after sync) belongs to slot k/8 at position k mod 8. Position 0 carries the word's MSB (bit 7).
- R5: With `rxEdgeSel`=0, `syncOut` and `txdOut` change on the rising edge of `sckOut` and `rxdIn` is sampled on the falling edge. With `rxEdgeSel`=1, these edges are swapped.
- R6: When transmit is enabled, `txReady` is high for exactly one system cycle, just before the bit period of position 0 of slot `txSlotSel`. The word on `txData` is taken if `txValid` is high in that cycle.
- R7: If `txValid` is low while `txReady` is high, that slot is sent as all zeros, and `txUnderrun` is high for the one following system cycle.
- R8: `txdOut` is low outside the transmit slot, while `txEnable` is 0, and whenever `txSlotSel` is at or above the slot count.
- R9: After the bit at position 7 of slot `rxSlotSel` is sampled, `rxValid` pulses for one cycle. `rxData` then holds the 8 sampled bits, with the first one as the MSB. Bits of `rxdIn` outside that slot do not affect `rxData`.
- R10: No `rxValid` pulse occurs while `rxEnable` is 0 or while `rxSlotSel` is at or above the slot count.
- R11: During reset, `syncOut`, `txdOut`, `txReady`, `rxValid` and `txUnderrun` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| clkDiv | input | DIV_W | Bit-clock half period minus one, in system cycles |
| frameLenCode | input | 4 | Coded frame length, bits [3:2] select 1 to 4 slots |
| txEnable | input | 1 | Transmit enable |
| rxEnable | input | 1 | Receive enable |
| txSlotSel | input | SLOT_W | Slot number used for transmit |
| rxSlotSel | input | SLOT_W | Slot number used for receive |
| rxEdgeSel | input | 1 | 0: sample on falling edge, 1: sample on rising edge |
| txValid | input | 1 | Transmit word offered |
| txReady | output | 1 | Transmit word taken this cycle |
| txData | input | WORD_W | Transmit word |
| sckOut | output | 1 | Bit clock |
| syncOut | output | 1 | Frame sync pulse |
| txdOut | output | 1 | Serial transmit data |
| rxdIn | input | 1 | Serial receive data |
| rxValid | output | 1 | Received word strobe |
| rxData | output | WORD_W | Received word |
| txUnderrun | output | 1 | Slot sent empty because no word was offered |

## Verification
A frame position counter that is off by one moves the sync pulse off its place by one bit period. That error shows at the very next launch edge, and it also shifts the `txReady` request and the bits on `txdOut`. A wrong divider count shows in the spacing of the next `sckOut` toggle. A stuck receive shifter or a wrong slot decode shows at the first `rxValid` strobe, which is at most one frame after reset: the strobe comes late or never, or carries a word that differs from the bits driven in the slot. Random noise on `rxdIn` outside the slot reveals any leakage from other slots in the same word.

// File: rtl/sap_pkg.sv
package sap_pkg;
  // Per-cycle strobes from the control to the datapath
  typedef struct packed {
    logic launch;    // bit period begins (tx/sync edge)
    logic syncNext;  // new bit period is the sync period
    logic txActive;  // new bit period lies in the transmit slot
    logic txLoad;    // new bit period is slot position 0
    logic rxActive;  // sample rxd now
    logic rxLast;    // this sample completes the word
  } sapStrobe_t;
endpackage

// File: rtl/sap_ctrl.sv
module sap_ctrl
  import sap_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int WORD_W = 8,
  parameter int SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  clkDiv,
  input  logic [3:0]        lenCode,
  input  logic              txEn,
  input  logic              rxEn,
  input  logic [SLOT_W-1:0] txSlot,
  input  logic [SLOT_W-1:0] rxSlot,
  input  logic              edgeSel,
  output logic              sckQ,
  output sapStrobe_t        strb
);
  localparam int BIT_W = $clog2(WORD_W);
  localparam int IDX_W = BIT_W + 2;

  logic [DIV_W-1:0] divCnt;
  logic [IDX_W-1:0] idx, nextIdx, lastIdx;
  logic             idle, toggle, launch, capture;
  logic             txHit, rxHit;

  assign toggle  = (divCnt == clkDiv);
  // launch edge: rising when edgeSel=0, falling when edgeSel=1
  assign launch  = toggle && (sckQ == edgeSel);
  assign capture = toggle && (sckQ != edgeSel) && !idle;
  assign lastIdx = {lenCode[3:2], {BIT_W{1'b1}}};

  always_comb begin
    if (idle)                nextIdx = lastIdx;
    else if (idx == lastIdx) nextIdx = '0;
    else                     nextIdx = idx + 1'b1;
  end

  assign txHit = txEn && (txSlot == {{(SLOT_W-2){1'b0}}, nextIdx[IDX_W-1:BIT_W]});
  assign rxHit = rxEn && (rxSlot == {{(SLOT_W-2){1'b0}}, idx[IDX_W-1:BIT_W]});

  always_comb begin
    strb.launch   = launch;
    strb.syncNext = (nextIdx == lastIdx);
    strb.txActive = launch && txHit;
    strb.txLoad   = launch && txHit && (nextIdx[BIT_W-1:0] == '0);
    strb.rxActive = capture && rxHit;
    strb.rxLast   = capture && rxHit && (&idx[BIT_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
      sckQ   <= 1'b0;
      idle   <= 1'b1;
      idx    <= '0;
    end else begin
      divCnt <= toggle ? '0 : divCnt + 1'b1;
      if (toggle) sckQ <= ~sckQ;
      if (launch) begin
        idx  <= nextIdx;
        idle <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sap_datapath.sv
module sap_datapath
  import sap_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  sapStrobe_t        strb,
  input  logic              txValid,
  input  logic [WORD_W-1:0] txData,
  input  logic              rxd,
  output logic              syncQ,
  output logic              txdQ,
  output logic              underQ,
  output logic              rxValidQ,
  output logic [WORD_W-1:0] rxDataQ
);
  logic [WORD_W-1:0] txShift, rxShift, loadWord;

  assign loadWord = txValid ? txData : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ    <= 1'b0;
      txdQ     <= 1'b0;
      underQ   <= 1'b0;
      rxValidQ <= 1'b0;
      txShift  <= '0;
      rxShift  <= '0;
      rxDataQ  <= '0;
    end else begin
      underQ   <= strb.txLoad && !txValid;
      rxValidQ <= strb.rxLast;
      if (strb.launch) begin
        syncQ <= strb.syncNext;
        if (strb.txLoad) begin
          txdQ    <= loadWord[WORD_W-1];
          txShift <= {loadWord[WORD_W-2:0], 1'b0};
        end else if (strb.txActive) begin
          txdQ    <= txShift[WORD_W-1];
          txShift <= {txShift[WORD_W-2:0], 1'b0};
        end else begin
          txdQ <= 1'b0;
        end
      end
      if (strb.rxActive) rxShift <= {rxShift[WORD_W-2:0], rxd};
      if (strb.rxLast)   rxDataQ <= {rxShift[WORD_W-2:0], rxd};
    end
  end
endmodule

// File: rtl/slot_audio_port.sv
module slot_audio_port
  import sap_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int WORD_W = 8,
  parameter int SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  clkDiv,
  input  logic [3:0]        frameLenCode,
  input  logic              txEnable,
  input  logic              rxEnable,
  input  logic [SLOT_W-1:0] txSlotSel,
  input  logic [SLOT_W-1:0] rxSlotSel,
  input  logic              rxEdgeSel,
  input  logic              txValid,
  output logic              txReady,
  input  logic [WORD_W-1:0] txData,
  output logic              sckOut,
  output logic              syncOut,
  output logic              txdOut,
  input  logic              rxdIn,
  output logic              rxValid,
  output logic [WORD_W-1:0] rxData,
  output logic              txUnderrun
);
  sapStrobe_t strb;

  sap_ctrl #(.DIV_W(DIV_W), .WORD_W(WORD_W), .SLOT_W(SLOT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .clkDiv(clkDiv), .lenCode(frameLenCode),
    .txEn(txEnable), .rxEn(rxEnable), .txSlot(txSlotSel), .rxSlot(rxSlotSel),
    .edgeSel(rxEdgeSel), .sckQ(sckOut), .strb(strb)
  );

  sap_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .txValid(txValid), .txData(txData),
    .rxd(rxdIn), .syncQ(syncOut), .txdQ(txdOut), .underQ(txUnderrun),
    .rxValidQ(rxValid), .rxDataQ(rxData)
  );

  assign txReady = strb.txLoad;
endmodule

// File: rtl/sap_checker.sv
module sap_checker (
  input logic clk,
  input logic rstN,
  input logic txEnable,
  input logic rxEnable,
  input logic txValid,
  input logic txReady,
  input logic sckOut,
  input logic syncOut,
  input logic txdOut,
  input logic rxValid,
  input logic txUnderrun
);
  // R6
  txready_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    txReady |=> !txReady);
  // R7
  underrun_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    txUnderrun |-> $past(txReady && !txValid));
  // R9
  rxvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);
  // R5
  sync_on_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(syncOut) |-> !$stable(sckOut));
  // R5
  txd_on_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(txdOut) |-> !$stable(sckOut));
  // R8
  txd_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txEnable |=> !txdOut);
  // R10
  rx_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> !rxValid);
endmodule

bind slot_audio_port sap_checker u_sap_chk (
  .clk(clk), .rstN(rstN), .txEnable(txEnable), .rxEnable(rxEnable),
  .txValid(txValid), .txReady(txReady), .sckOut(sckOut), .syncOut(syncOut),
  .txdOut(txdOut), .rxValid(rxValid), .txUnderrun(txUnderrun)
);

// File: tb/slot_audio_port_bench.sv
module slot_audio_port_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rstN = 1'b0;
  logic [7:0] clkDiv = '0;
  logic [3:0] frameLenCode = '0;
  logic       txEnable = 1'b0, rxEnable = 1'b0, rxEdgeSel = 1'b0;
  logic [3:0] txSlotSel = '0, rxSlotSel = '0;
  logic       txValid = 1'b0;
  logic [7:0] txData = '0;
  logic       rxdIn = 1'b0;
  logic       txReady, sckOut, syncOut, txdOut, rxValid, txUnderrun;
  logic [7:0] rxData;

  slot_audio_port u_slot_audio_port (
    .clk(clk), .rstN(rstN), .clkDiv(clkDiv), .frameLenCode(frameLenCode),
    .txEnable(txEnable), .rxEnable(rxEnable), .txSlotSel(txSlotSel),
    .rxSlotSel(rxSlotSel), .rxEdgeSel(rxEdgeSel), .txValid(txValid),
    .txReady(txReady), .txData(txData), .sckOut(sckOut), .syncOut(syncOut),
    .txdOut(txdOut), .rxdIn(rxdIn), .rxValid(rxValid), .rxData(rxData),
    .txUnderrun(txUnderrun)
  );

  int errors = 0, checks = 0, cyc = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected frame length from R2
  function automatic int lastIdxOf(input logic [3:0] code);
    return 8 * (int'(code[3:2]) + 1) - 1;
  endfunction

  // Monitor / peripheral model state
  bit mon = 0, started, firstToggle, readySeen, underPend, advance;
  logic prevSck;
  int halfCnt, m, lastM;
  logic [7:0] curTx, rxWord;

  always @(negedge clk) if (mon) begin
    halfCnt++;
    // R7: underrun strobe one cycle after an empty handshake
    chk(txUnderrun == underPend, "R7 underrun strobe", txUnderrun, underPend);
    underPend = 0;
    if (txReady) begin
      curTx = txValid ? txData : 8'h00;
      underPend = !txValid;
      readySeen = 1;
      advance = 1;
    end else if (advance) begin
      txValid = ($urandom % 4) != 0;
      txData  = 8'($urandom);
      advance = 0;
    end
    if (sckOut !== prevSck) begin
      if (!firstToggle) chk(halfCnt == int'(clkDiv) + 1, "R1 half period", halfCnt, int'(clkDiv) + 1);
      firstToggle = 0;
      halfCnt = 0;
      if (prevSck == rxEdgeSel) begin : launchEdge
        bit inTx, inRx;
        int b;
        if (!started) begin
          chk(syncOut == 1'b1, "R3 first period is sync", syncOut, 1);
          started = 1;
          m = lastM;
        end else begin
          m = (m == lastM) ? 0 : m + 1;
          chk(syncOut == (m == lastM), "R2 R3 sync position", syncOut, int'(m == lastM));
        end
        b = m % 8;
        inTx = txEnable && (m / 8 == int'(txSlotSel)) && m != lastM + 1;
        if (m == lastM && started && lastM == 7 && !inTx) inTx = 0;
        // R6: request exactly before slot position 0
        chk(readySeen == (inTx && b == 0), "R6 ready timing", readySeen, int'(inTx && b == 0));
        readySeen = 0;
        // R4 R8: MSB-first slot data, low elsewhere
        chk(txdOut == (inTx ? curTx[7-b] : 1'b0), "R4 R8 txd bit", txdOut, inTx ? int'(curTx[7-b]) : 0);
        inRx = rxEnable && (m / 8 == int'(rxSlotSel));
        if (inRx) begin
          if (b == 0) rxWord = 8'($urandom);
          rxdIn = rxWord[7-b];
        end else begin
          rxdIn = 1'($urandom);   // noise outside slot
        end
      end else begin : captureEdge
        bit expV;
        expV = started && rxEnable && (m / 8 == int'(rxSlotSel)) && (m % 8 == 7);
        chk(rxValid == expV, "R9 R10 rxValid at sample", rxValid, int'(expV));
        if (expV) chk(rxData == rxWord, "R9 rxData word", rxData, rxWord);
      end
      prevSck = sckOut;
    end else begin
      chk(rxValid == 1'b0, "R9 rxValid one-cycle", rxValid, 0);
    end
  end

  task automatic runPhase(input int div, input logic [3:0] code, input bit te, input bit re,
                          input int ts, input int rs, input bit edgeSel, input int frames);
    mon = 0;
    rstN = 0;
    clkDiv = 8'(div); frameLenCode = code;
    txEnable = te; rxEnable = re;
    txSlotSel = 4'(ts); rxSlotSel = 4'(rs); rxEdgeSel = edgeSel;
    txValid = ($urandom % 4) != 0;
    txData = 8'($urandom);
    rxdIn = 0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(sckOut == 0 && syncOut == 0 && txdOut == 0, "R11 reset serial lines", {sckOut, syncOut, txdOut}, 0);
    chk(rxValid == 0 && txUnderrun == 0 && txReady == 0, "R11 reset strobes", {rxValid, txUnderrun, txReady}, 0);
    started = 0; firstToggle = 1; readySeen = 0; underPend = 0; advance = 0;
    prevSck = 1'b0; halfCnt = 0; m = 0; curTx = 0; rxWord = 0;
    lastM = lastIdxOf(code);
    rstN = 1;
    mon = 1;
    repeat ((lastM + 1) * 2 * (div + 1) * frames + 20) @(negedge clk);
    mon = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240517));
    // directed: 8-bit frame, slot 0 both ways, falling-edge sampling (R2 R3 R4 R5)
    runPhase(1, 4'b0000, 1, 1, 0, 0, 0, 8);
    // 16-bit frame, slot 1 unused
    runPhase(2, 4'b0100, 1, 1, 0, 0, 0, 6);
    // fastest divider, rising-edge sampling, different slots (R1 R5)
    runPhase(0, 4'b0100, 1, 1, 1, 0, 1, 8);
    // 24-bit frame
    runPhase(3, 4'b1000, 1, 1, 2, 1, 1, 4);
    // 32-bit frame, last slot
    runPhase(1, 4'b1100, 1, 1, 3, 3, 0, 4);
    // low code bits ignored (R2)
    runPhase(1, 4'b0111, 1, 1, 1, 1, 0, 4);
    // both directions disabled (R8 R10)
    runPhase(1, 4'b0100, 0, 0, 0, 0, 0, 4);
    // slots beyond the frame (R8 R10)
    runPhase(1, 4'b0100, 1, 1, 3, 2, 1, 4);
    // random configurations
    for (int i = 0; i < 6; i++) begin
      logic [3:0] c;
      c = 4'($urandom);
      runPhase(int'($urandom % 4), c, 1, 1, int'($urandom % 4), int'($urandom % 4),
               1'($urandom), 3);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule